// File: doc/BRIEF.md
# Machine Timer with 64-bit Compare

This block holds a 64-bit up-counter and a 64-bit compare value, both reached as pairs of 32-bit words over a simple single-cycle register bus. The counter advances on an external tick pulse or, when the fast mode is selected, on every clock. While a debug-halt input is high and the matching pause bit is set, the counter holds its value. An interrupt output stays high for as long as the counter is at or past the compare value.

Software programs the compare value to schedule an interrupt. It reads the counter as two halves. The compare value starts at all-ones, so the interrupt stays low after reset until software programs a compare value.

Top module: `mach_timer`

## Requirements
- R1: After reset, the control word reads 0xD. Its fields are enable at bit 0, fast mode at bit 1, core-0 pause at bit 2 and core-1 pause at bit 3. Both counter halves read 0, and both compare halves read 0xFFFFFFFF.
- R2: With enable=1 and fast=0, the counter rises by exactly one on each clock edge at which tick_i is high, and holds otherwise.
- R3: With enable=1 and fast=1, the counter rises by one on every clock edge, whatever tick_i is.
- R4: The counter behaves as one 64-bit value. A low half of 0xFFFFFFFF wraps to 0, and the high half rises by one on the same edge.
- R5: With enable=0, the counter does not advance, whatever the fast bit and tick_i are.
- R6: While dbg_halt_i[n] is high and pause bit n is set, the counter holds. A halt input whose pause bit is clear has no effect.
- R7: A bus write to either counter half on an edge suppresses the increment on that edge. The written half takes the write data, and the other half keeps its value.
- R8: irq_o is high exactly when the unsigned 64-bit counter is greater than or equal to the 64-bit compare value.
- R9: The read map is: address 0 control (bits 31:4 read 0), 1 counter low, 2 counter high, 3 compare low, 4 compare high. Addresses 5 to 7 read 0.
- R10: Both compare halves are writable, each independently of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Increment pulse, used when fast mode is off |
| dbg_halt_i | input | 2 | Per-core debug-halt indication |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word select |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Timer interrupt |

## Verification
Assertions are checked on every cycle for these properties:
- the counter is frozen when enable is clear;
- the counter is frozen during a paused debug halt;
- the carry between the halves happens on the increment edge;
- a half write wins over an increment;
- equality with the compare value implies an interrupt.

Only the bench scenarios can show the rest:
- the exact increment counts in tick and fast modes;
- the reset values and the register read map;
- the interrupt switching on and off when the high half decides the comparison.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;
  localparam int ADDR_W = 3;
  localparam int NCORE  = 2;
  localparam int CTRL_W = 2 + NCORE;
  localparam int EN_BIT   = 0;
  localparam int FAST_BIT = 1;
  localparam int PAUSE_LSB = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL = 3'd0,
    SEL_TLO  = 3'd1,
    SEL_THI  = 3'd2,
    SEL_CLO  = 3'd3,
    SEL_CHI  = 3'd4
  } reg_sel_e;

  localparam logic [CTRL_W-1:0] CTRL_RST = {{NCORE{1'b1}}, 1'b0, 1'b1};
endpackage

// File: rtl/mtimer_ctrl.sv
module mtimer_ctrl
  import mtimer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              tick_i,
  input  logic [NCORE-1:0]  dbg_halt_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              adv_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [NCORE-1:0]  hold;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= CTRL_RST;
    else if (we_i) ctrl_q <= wdata_i;
  end

  for (genvar c = 0; c < NCORE; c++) begin : g_hold
    assign hold[c] = ctrl_q[PAUSE_LSB+c] & dbg_halt_i[c];
  end

  assign adv_o  = ctrl_q[EN_BIT] & (ctrl_q[FAST_BIT] | tick_i) & ~(|hold);
  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/mtimer_count.sv
module mtimer_count #(
  parameter int DW = 32,
  localparam int TW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          we_lo_i,
  input  logic          we_hi_i,
  input  logic [DW-1:0] wdata_i,
  output logic [TW-1:0] cnt_o
);
  logic [DW-1:0] lo_q, hi_q;

  // any half write blocks the increment for that edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (we_lo_i || we_hi_i) begin
      if (we_lo_i) lo_q <= wdata_i;
      if (we_hi_i) hi_q <= wdata_i;
    end else if (inc_i) begin
      {hi_q, lo_q} <= {hi_q, lo_q} + TW'(1);
    end
  end

  assign cnt_o = {hi_q, lo_q};

  // R4
  carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !we_lo_i && !we_hi_i && (&lo_q) |=> lo_q == '0 && hi_q == $past(hi_q) + DW'(1));

  // R7
  write_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_lo_i && !we_hi_i |=> lo_q == $past(wdata_i) && hi_q == $past(hi_q));
endmodule

// File: rtl/mtimer_cmp.sv
module mtimer_cmp #(
  parameter int DW = 32,
  localparam int TW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_lo_i,
  input  logic          we_hi_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [TW-1:0] cnt_i,
  output logic [TW-1:0] cmp_o,
  output logic          irq_o
);
  logic [DW-1:0] lo_q, hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '1;
      hi_q <= '1;
    end else begin
      if (we_lo_i) lo_q <= wdata_i;
      if (we_hi_i) hi_q <= wdata_i;
    end
  end

  assign cmp_o = {hi_q, lo_q};
  assign irq_o = cnt_i >= cmp_o;

  // R10
  cmp_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_lo_i && !we_hi_i |=> lo_q == $past(wdata_i) && $stable(hi_q));
endmodule

// File: rtl/mach_timer.sv
module mach_timer
  import mtimer_pkg::*;
#(
  parameter int DW = 32,
  localparam int TW = 2 * DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [NCORE-1:0]  dbg_halt_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              irq_o
);
  logic [CTRL_W-1:0] ctrl;
  logic              adv;
  logic [TW-1:0]     cnt, cmp;
  logic              we_ctrl, we_tlo, we_thi, we_clo, we_chi;

  assign we_ctrl = we_i && addr_i == SEL_CTRL;
  assign we_tlo  = we_i && addr_i == SEL_TLO;
  assign we_thi  = we_i && addr_i == SEL_THI;
  assign we_clo  = we_i && addr_i == SEL_CLO;
  assign we_chi  = we_i && addr_i == SEL_CHI;

  mtimer_ctrl u_ctrl (
    .clk_i, .rst_ni, .we_i(we_ctrl), .wdata_i(wdata_i[CTRL_W-1:0]),
    .tick_i, .dbg_halt_i, .ctrl_o(ctrl), .adv_o(adv)
  );

  mtimer_count #(.DW(DW)) u_count (
    .clk_i, .rst_ni, .inc_i(adv), .we_lo_i(we_tlo), .we_hi_i(we_thi),
    .wdata_i, .cnt_o(cnt)
  );

  mtimer_cmp #(.DW(DW)) u_cmp (
    .clk_i, .rst_ni, .we_lo_i(we_clo), .we_hi_i(we_chi),
    .wdata_i, .cnt_i(cnt), .cmp_o(cmp), .irq_o
  );

  always_comb begin
    unique case (addr_i)
      SEL_CTRL: rdata_o = DW'(ctrl);
      SEL_TLO:  rdata_o = cnt[DW-1:0];
      SEL_THI:  rdata_o = cnt[TW-1:DW];
      SEL_CLO:  rdata_o = cmp[DW-1:0];
      SEL_CHI:  rdata_o = cmp[TW-1:DW];
      default:  rdata_o = '0;
    endcase
  end

  // R5
  en_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl[EN_BIT] && !we_tlo && !we_thi |=> $stable(cnt));

  for (genvar c = 0; c < NCORE; c++) begin : g_pause_chk
    // R6
    pause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ctrl[PAUSE_LSB+c] && dbg_halt_i[c] && !we_tlo && !we_thi |=> $stable(cnt));
  end

  // R8
  irq_eq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt == cmp |-> irq_o);
endmodule

// File: tb/tb_mach_timer.sv
`timescale 1ns/1ps
module tb_mach_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic [1:0]  dbg_halt_i = '0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // bit 32 set: compare irq_o instead of rdata_o
  logic [32:0] exp_q[$];
  string       tag_q[$];

  mach_timer dut (.*);

  always #2 clk_i = ~clk_i;

  // monitor
  always @(negedge clk_i) begin
    if (exp_q.size() > 0) begin
      logic [32:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (e[32]) begin
        if (irq_o !== e[0]) begin
          n_bad++;
          $display("FAIL %s: irq_o=%0b expected %0b", t, irq_o, e[0]);
        end
      end else if (rdata_o !== e[31:0]) begin
        n_bad++;
        $display("FAIL %s: addr %0d rdata=%h expected %h", t, addr_i, rdata_o, e[31:0]);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input bit tk = 0);
    @(posedge clk_i); #1;
    we_i = 1'b1; addr_i = a; wdata_i = d; tick_i = tk;
    @(posedge clk_i); #1;
    we_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i); #1; tick_i = 1'b1;
      @(posedge clk_i); #1; tick_i = 1'b0;
    end
  endtask

  task automatic expect_rd(input logic [2:0] a, input logic [31:0] e, input string t);
    @(posedge clk_i); #1;
    addr_i = a;
    exp_q.push_back({1'b0, e});
    tag_q.push_back(t);
    @(negedge clk_i); #1;
  endtask

  task automatic expect_irq(input logic e, input string t);
    @(posedge clk_i); #1;
    exp_q.push_back({1'b1, 31'd0, e});
    tag_q.push_back(t);
    @(negedge clk_i); #1;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset values
    expect_rd(3'd0, 32'hD, "R1 ctrl");
    expect_rd(3'd1, 32'h0, "R1 tlo");
    expect_rd(3'd2, 32'h0, "R1 thi");
    expect_rd(3'd3, 32'hFFFF_FFFF, "R1 clo");
    expect_rd(3'd4, 32'hFFFF_FFFF, "R1 chi");
    expect_irq(1'b0, "R1 R8 irq at reset");

    // R2 tick mode
    ticks(5);
    expect_rd(3'd1, 32'd5, "R2 five ticks");

    // R4 carry
    wr(3'd1, 32'hFFFF_FFFE);
    wr(3'd2, 32'd3);
    ticks(3);
    expect_rd(3'd1, 32'd1, "R4 lo wrap");
    expect_rd(3'd2, 32'd4, "R4 hi carry");

    // R5 disabled, fast set
    wr(3'd0, 32'h2);
    ticks(4);
    repeat (6) @(posedge clk_i);
    expect_rd(3'd1, 32'd1, "R5 en=0 lo held");
    expect_rd(3'd2, 32'd4, "R5 en=0 hi held");

    // R3 fast mode: K=10 idle edges plus two edges of the disabling write
    wr(3'd1, 32'd100);
    wr(3'd2, 32'd0);
    wr(3'd0, 32'h3);
    repeat (10) @(posedge clk_i);
    wr(3'd0, 32'h0);
    expect_rd(3'd1, 32'd112, "R3 fast count");

    // R6 pause gating
    wr(3'd0, 32'hD);
    wr(3'd1, 32'd0);
    dbg_halt_i = 2'b01;
    ticks(4);
    expect_rd(3'd1, 32'd0, "R6 core0 paused");
    dbg_halt_i = 2'b10;
    ticks(4);
    expect_rd(3'd1, 32'd0, "R6 core1 paused");
    wr(3'd0, 32'h1);
    dbg_halt_i = 2'b11;
    ticks(3);
    expect_rd(3'd1, 32'd3, "R6 halts ignored without pause");
    wr(3'd0, 32'h5);
    dbg_halt_i = 2'b10;
    ticks(2);
    expect_rd(3'd1, 32'd5, "R6 only core1 halted, core0 pause");
    dbg_halt_i = 2'b00;

    // R7 write priority over tick
    wr(3'd0, 32'h1);
    wr(3'd1, 32'h55, 1'b1);
    expect_rd(3'd1, 32'h55, "R7 lo write wins");
    expect_rd(3'd2, 32'h0, "R7 hi kept");
    wr(3'd2, 32'h7, 1'b1);
    expect_rd(3'd2, 32'h7, "R7 hi write wins");
    expect_rd(3'd1, 32'h55, "R7 lo kept");

    // R8 / R10 compare
    wr(3'd0, 32'h0);
    wr(3'd3, 32'h10);
    expect_rd(3'd4, 32'hFFFF_FFFF, "R10 chi untouched by clo write");
    wr(3'd4, 32'h1);
    expect_rd(3'd3, 32'h10, "R10 clo");
    expect_rd(3'd4, 32'h1, "R10 chi");
    wr(3'd1, 32'hF);
    wr(3'd2, 32'h1);
    expect_irq(1'b0, "R8 one below");
    wr(3'd0, 32'h1);
    ticks(1);
    expect_irq(1'b1, "R8 equal");
    wr(3'd0, 32'h0);
    wr(3'd1, 32'h0);
    wr(3'd2, 32'h2);
    expect_irq(1'b1, "R8 high half greater");
    wr(3'd2, 32'h0);
    wr(3'd1, 32'hFFFF_FFFF);
    expect_irq(1'b0, "R8 high half smaller");

    // R9 map
    wr(3'd0, 32'hFFFF_FFFC);
    expect_rd(3'd0, 32'hC, "R9 ctrl upper bits zero");
    expect_rd(3'd5, 32'h0, "R9 addr5");
    expect_rd(3'd7, 32'h0, "R9 addr7");

    repeat (2) @(posedge clk_i);
    done = 1;
    finish_run();
  end
endmodule